// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block is a clocked behavioural model of the control logic in a byte-wide flash memory that is erased as a whole chip. It sits behind a chip-select, a write strobe and an output enable, with an address bus, a data input byte and a program-voltage enable. While the program-voltage enable is low the part is a plain read-only memory. While it is high, bytes written on the bus are taken as commands. These commands select read-array mode, identifier mode, a two-write bulk erase, a two-write byte program, and verify reads that end an erase or program pulse.

The storage is a small array with `2**AW` bytes. Erasing sets every byte to FFh. Programming ANDs the new byte into the stored byte, so a bit can only go from 1 to 0. An internal stop counter ends any pulse after `ERASE_CYC` or `PROG_CYC` clock cycles, even when no verify command arrives. The `pulse_on` output shows while a pulse is running.

The states are:
- READ (array reads)
- IDENT (identifier reads)
- ERS_ARM (first erase write seen)
- ERASING (erase pulse)
- ERS_CHECK (erase verify)
- PGM_ARM (program setup seen)
- PROGRAMMING (program pulse)
- PGM_CHECK (program verify)

The transitions are:
- Every accepted write decodes its byte from any state, with two exceptions:
  - ERS_ARM followed by 20h goes to ERASING.
  - PGM_ARM followed by any write goes to PROGRAMMING.
- Unknown bytes go to READ.
- A low program-voltage enable forces READ.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_en` is low, writes are ignored: the array is not changed, no pulse runs, and reads return array data. When `vpp_en` goes low, the state becomes READ and any pulse stops. When `vpp_en` is raised again, the block stays in READ mode.
- R2: A bus write is accepted when all of the following hold: `ce_n` and `we_n` are both low for at least one clock, then either strobe goes high, `oe_n` is high throughout, and `vpp_en` is high. The command takes effect on the clock edge after the strobes are released.
- R3: Command 00h or FFh selects READ. In READ, reads return the array byte at the bus address.
- R4: Command 80h or 90h selects IDENT. In IDENT, a read with `addr[0]`=0 returns 01h and a read with `addr[0]`=1 returns 25h.
- R5: Two consecutive accepted writes of 20h set every array byte to FFh and start an erase pulse. If the write after the first 20h carries any other byte, that byte is decoded as a new command and no erase happens.
- R6: Command A0h ends any running pulse and latches the write address. Reads then return the array byte at that latched address, whatever address is on the bus.
- R7: After command 40h, the next accepted write ANDs its data into the byte at its address and starts a program pulse. Command C0h ends the pulse. Reads then return the byte at the latched program address.
- R8: The write address is taken in the first clock where both strobes are low. The data is taken in the last such clock. A write during which `oe_n` is low at any point is discarded.
- R9: A pulse that no command ends drops `pulse_on` after exactly `ERASE_CYC` clocks for an erase, or `PROG_CYC` clocks for a program.
- R10: Two consecutive writes of FFh leave the block in READ, from any state.
- R11: `dout_en` is high only when `ce_n` and `oe_n` are both low. At all other times `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array resets to FFh |
| vpp_en | input | 1 | Program-voltage enable; high enables the command register |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, 00h when not driven |
| dout_en | output | 1 | Read data valid |
| pulse_on | output | 1 | Erase or program pulse running |

## Verification
The assertions take the control strobes as synchronous levels that are held for whole clock cycles. They treat a write as one contiguous stretch with both strobes low. They also assume `vpp_en` changes only at clock granularity. The stimulus follows these assumptions: every input changes on the falling clock edge, each write keeps its strobes low for at least one full cycle, and `vpp_en` is only dropped between writes. The deliberate exceptions are a write made with `oe_n` low and strobes that overlap in a skewed order; both stay synchronous.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_IDENT,
        ST_ERS_ARM,
        ST_ERASING,
        ST_ERS_CHECK,
        ST_PGM_ARM,
        ST_PROGRAMMING,
        ST_PGM_CHECK
    } fstate_t;

    localparam logic [7:0] CMD_READ_Z = 8'h00;
    localparam logic [7:0] CMD_READ_F = 8'hFF;
    localparam logic [7:0] CMD_IDENT1 = 8'h80;
    localparam logic [7:0] CMD_IDENT2 = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_EVRFY  = 8'hA0;
    localparam logic [7:0] CMD_PSETUP = 8'h40;
    localparam logic [7:0] CMD_PVRFY  = 8'hC0;

    localparam logic [7:0] ID_MAKER = 8'h01;
    localparam logic [7:0] ID_PART  = 8'h25;

    function automatic fstate_t cmd_decode(input logic [7:0] d);
        fstate_t s;
        case (d)
            CMD_IDENT1, CMD_IDENT2: s = ST_IDENT;
            CMD_ERASE:              s = ST_ERS_ARM;
            CMD_EVRFY:              s = ST_ERS_CHECK;
            CMD_PSETUP:             s = ST_PGM_ARM;
            CMD_PVRFY:              s = ST_PGM_CHECK;
            default:                s = ST_READ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_en,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_done,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic act;
    logic act_q;
    logic spoil_q;

    assign act = !ce_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            spoil_q <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            act_q <= act;
            if (act) begin
                if (!act_q) begin
                    wr_addr <= addr;
                    spoil_q <= !oe_n;
                end else if (!oe_n) begin
                    spoil_q <= 1'b1;
                end
                wr_data <= din;
            end
        end
    end

    assign wr_done = act_q && !act && !spoil_q && vpp_en;

    p_oe_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !oe_n) |=> !wr_done);

endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
    parameter int ERASE_CYC = 40,
    parameter int PROG_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_erase,
    input  logic start_prog,
    input  logic stop,
    output logic running
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_erase) begin
            cnt <= CW'(ERASE_CYC);
        end else if (start_prog) begin
            cnt <= CW'(PROG_CYC);
        end else if (stop) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign running = (cnt != '0);

    p_start_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(start_erase || start_prog));

    p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start_erase && !start_prog) |=> !running);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_all,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_en) begin
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];

    p_erase_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (mem[0] == 8'hFF) && (mem[DEPTH-1] == 8'hFF));

    p_pgm_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_all) |=> ((mem[$past(prog_addr)] & ~$past(prog_data)) == 8'h00));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_pkg::*;
#(
    parameter int AW        = 4,
    parameter int ERASE_CYC = 40,
    parameter int PROG_CYC  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_en,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en,
    output logic          pulse_on
);
    fstate_t       state, nxt;
    logic          wr_done;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] vfy_addr, pgm_addr, rd_addr;
    logic [7:0]    rd_data;
    logic          erase_go, prog_go;

    flash_bus_capture #(.AW(AW)) u_bus (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_pulse_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_erase(erase_go), .start_prog(prog_go),
        .stop(wr_done || !vpp_en),
        .running(pulse_on)
    );

    flash_cell_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .erase_all(erase_go), .prog_en(prog_go),
        .prog_addr(wr_addr), .prog_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // next state and array strobes
    always_comb begin
        nxt      = state;
        erase_go = 1'b0;
        prog_go  = 1'b0;
        if (!vpp_en) begin
            nxt = ST_READ;
        end else if (wr_done) begin
            unique case (state)
                ST_ERS_ARM: begin
                    if (wr_data == CMD_ERASE) begin
                        nxt      = ST_ERASING;
                        erase_go = 1'b1;
                    end else begin
                        nxt = cmd_decode(wr_data);
                    end
                end
                ST_PGM_ARM: begin
                    nxt     = ST_PROGRAMMING;
                    prog_go = 1'b1;
                end
                default: nxt = cmd_decode(wr_data);
            endcase
        end
    end

    // state register and latched addresses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_READ;
            vfy_addr <= '0;
            pgm_addr <= '0;
        end else begin
            state <= nxt;
            if (wr_done && vpp_en) begin
                if (state == ST_PGM_ARM) pgm_addr <= wr_addr;
                if (nxt == ST_ERS_CHECK) vfy_addr <= wr_addr;
            end
        end
    end

    // read outputs
    always_comb begin
        logic [7:0] val;
        dout_en = !ce_n && !oe_n;
        rd_addr = addr;
        val     = 8'h00;
        unique case (state)
            ST_IDENT:     val = addr[0] ? ID_PART : ID_MAKER;
            ST_ERS_CHECK: begin rd_addr = vfy_addr; val = rd_data; end
            ST_PGM_CHECK: begin rd_addr = pgm_addr; val = rd_data; end
            default:      val = rd_data;
        endcase
        dout = dout_en ? val : 8'h00;
    end

    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_en |=> (state == ST_READ) && !pulse_on);

    p_erase_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING && $past(state) != ST_ERASING) |-> $past(state) == ST_ERS_ARM);

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dout == 8'h00) && !dout_en);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int AW = 4;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vpp_en = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, pulse_on;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit mon_go = 1'b0;

    int         sel_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .pulse_on(pulse_on)
    );

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        #2;
        if (mon_go) begin
            while (sel_q.size() > 0) begin
                int sel;
                logic [7:0] e, a;
                string t;
                sel = sel_q.pop_front();
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                case (sel)
                    0: a = dout_en ? dout : 8'hXX;
                    1: a = {7'b0, pulse_on};
                    default: a = {7'b0, dout_en};
                endcase
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [7:0] e, input string t);
        sel_q.push_back(sel);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; addr = ~a; din = ~d;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        push(0, e, t);
        mon_go = 1'b1;
        @(negedge clk);
        mon_go = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic chk_pulse(input logic e, input string t);
        @(negedge clk);
        push(1, {7'b0, e}, t);
        mon_go = 1'b1;
        @(negedge clk);
        mon_go = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(4'd3, 8'hFF, "R3 reset array reads FFh");
        chk_pulse(1'b0, "R9 no pulse after reset");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        push(0, 8'hXX, "R11 idle dout");
        push(2, 8'h00, "R11 dout_en low with ce_n high");
        mon_go = 1'b1;
        @(negedge clk);
        mon_go = 1'b0; oe_n = 1'b1;

        // R1: writes ignored with vpp low
        wr(4'd2, 8'h40);
        wr(4'd2, 8'h00);
        chk_pulse(1'b0, "R1 no pulse when vpp low");
        rd(4'd2, 8'hFF, "R1 array unchanged when vpp low");

        vpp_en = 1'b1;
        rd(4'd2, 8'hFF, "R1 read mode after vpp rise");

        // R7: program then verify
        wr(4'd0, 8'h40);
        wr(4'd5, 8'h3C);
        chk_pulse(1'b1, "R7 program pulse running");
        wr(4'd0, 8'hC0);
        chk_pulse(1'b0, "R7 C0h ends pulse");
        rd(4'd0, 8'h3C, "R7 program verify at latched address");
        wr(4'd0, 8'h00);
        rd(4'd5, 8'h3C, "R3 read array programmed byte");
        rd(4'd6, 8'hFF, "R3 read array untouched byte");

        // R9: program pulse timeout, AND behaviour
        wr(4'd0, 8'h40);
        wr(4'd5, 8'hF0);
        repeat (PROG_CYC - 2) @(negedge clk);
        chk_pulse(1'b1, "R9 program pulse before timeout");
        repeat (3) @(negedge clk);
        chk_pulse(1'b0, "R9 program pulse after timeout");
        wr(4'd0, 8'hFF);
        rd(4'd5, 8'h30, "R7 program ANDs into byte");

        // R4: identifier
        wr(4'd0, 8'h90);
        rd(4'd0, 8'h01, "R4 ident addr0 low");
        rd(4'd1, 8'h25, "R4 ident addr0 high");
        wr(4'd0, 8'h80);
        rd(4'd3, 8'h25, "R4 ident via 80h");
        // R10: FF FF reset
        wr(4'd0, 8'hFF);
        wr(4'd0, 8'hFF);
        rd(4'd5, 8'h30, "R10 read mode after FF FF");

        // R5: broken pair
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h40);
        chk_pulse(1'b0, "R5 broken pair starts no erase");
        wr(4'd7, 8'h0F);
        wr(4'd0, 8'hC0);
        rd(4'd9, 8'h0F, "R5 broken pair second byte taken as command");
        wr(4'd0, 8'h00);
        rd(4'd5, 8'h30, "R5 no erase after broken pair");

        // R5/R6: erase and verify
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        repeat (ERASE_CYC - 4) @(negedge clk);
        chk_pulse(1'b1, "R5 erase pulse running");
        wr(4'd7, 8'hA0);
        chk_pulse(1'b0, "R6 A0h ends erase pulse");
        rd(4'd0, 8'hFF, "R6 erase verify at latched address 7");
        wr(4'd5, 8'hA0);
        rd(4'd1, 8'hFF, "R6 erase verify at latched address 5");
        wr(4'd0, 8'h00);
        rd(4'd7, 8'hFF, "R5 erase sets byte to FFh");

        // R9: erase timeout
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        repeat (ERASE_CYC - 2) @(negedge clk);
        chk_pulse(1'b1, "R9 erase pulse before timeout");
        repeat (3) @(negedge clk);
        chk_pulse(1'b0, "R9 erase pulse after timeout");

        // R8: skewed strobes, address at start, data at end
        wr(4'd0, 8'h40);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; addr = 4'd12; din = 8'h00;
        @(negedge clk);
        we_n = 1'b0; addr = 4'd3; din = 8'h11;
        @(negedge clk);
        addr = 4'd12; din = 8'h55;
        @(negedge clk);
        ce_n = 1'b1; din = 8'hAA;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        wr(4'd0, 8'hC0);
        rd(4'd12, 8'h55, "R8 data from last cycle, address from first");
        wr(4'd0, 8'h00);
        rd(4'd12, 8'hFF, "R8 later address not used");

        // R8: oe low during write discards it
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 4'd4; din = 8'h40;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        wr(4'd4, 8'h00);
        rd(4'd4, 8'hFF, "R8 write with oe low ignored");

        // R1: vpp drop during pulse
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        @(negedge clk);
        vpp_en = 1'b0;
        @(negedge clk);
        chk_pulse(1'b0, "R1 vpp drop stops pulse");
        vpp_en = 1'b1;
        rd(4'd3, 8'hFF, "R1 read mode after vpp cycle");

        // R2: a write takes effect only after strobe release
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 4'd1; din = 8'h90;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        rd(4'd1, 8'h25, "R2 command applied after strobe release");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule